// File: doc/BRIEF.md
# Transceiver Power-Mode Sequencer

This block is the power-management controller for a baseband transceiver that has four power domains: the auxiliary converters, the transmit path, the receive path and the shared bias network. Software writes four small control registers. The block turns those writes into power-down, enable and clock-stop outputs for each domain, and it enforces two ordering rules:

- The transmit enable stays high until the transmit datapath reports that it is empty.
- Neither path is switched on until the bias node has had its full recovery time.

Each domain has a cycle-count timer, sized by a parameter, that raises a ready flag once the domain's wake-up time has passed. The auxiliary ADC powers itself down when no channel is selected. In single-shot mode it stays powered only for the span between a conversion request and the matching done pulse. A path enable requested while the bias is still recovering is held as pending. A wait flag reports it, and it takes effect by itself once recovery completes.

Register map, with the write address on `wr_addr`:

| Address | Register | Fields |
|---|---|---|
| 0 | power | bit0 bias off, bits[4:1] DAC3..DAC0 off, bit5 receive anti-alias filter off, bit6 bias chain off |
| 1 | transmit | bit0 transmit request |
| 2 | receive | bit0 receive request |
| 3 | auxiliary | bits[3:0] ADC channel (0 means none), bit4 single-shot, bit5 RAM-DAC in use, bit6 auxiliary clock-stop request |

Top module: `xcvr_pwr_seq`

## Requirements
- R1: While `rst` is high and after it is released, every domain is powered down: `dac_pd`=4'hF, `adc_pd`=1, `bias_pd`=1, `bias_chain_pd`=1, `rx_aaf_pd`=1, all enables low, all ready flags low, and `tx_clk_stop`, `rx_clk_stop`, `rx_if_clk_stop` and `aux_clk_stop` high.
- R2: Power register bits [4:1] drive `dac_pd[3:0]` directly, one bit per DAC. `dac_rdy[i]` rises DAC_CYC cycles after the write that clears `dac_pd[i]`, and it drops once that DAC is powered down again.
- R3: With single-shot mode off (auxiliary bit4=0), the ADC is powered (`adc_pd`=0) one cycle after a nonzero channel is written in bits[3:0]. It powers down one cycle after channel 0 is written.
- R4: In single-shot mode (bit4=1), the ADC stays down until an `adc_conv_req` pulse powers it up on the next edge. `adc_rdy` follows within four cycles of that edge, and an `adc_conv_done` pulse powers the ADC down again.
- R5: `aux_clk_stop` is high only when the clock-stop request (bit6) is set, the channel is 0 and the RAM-DAC bit (bit5) is clear. It updates one cycle after the write.
- R6: Setting transmit bit0 raises `tx_en` and `tx_ctrl_en` and lowers `tx_clk_stop`. Clearing it does not drop `tx_en` while `tx_path_active` is high. The enable drops on the first edge at which `tx_path_active` is seen low.
- R7: Receive bit0 drives `rx_en`. `rx_clk_stop` and `rx_if_clk_stop` are high whenever `rx_en` is low. Power register bit5 drives `rx_aaf_pd` independently of `rx_en`.
- R8: `bias_rdy` rises BIAS_CYC cycles after both bias bits (power bits 0 and 6) are clear, and it falls one cycle after either bit is set. `tx_en` and `rx_en` never rise unless `bias_rdy` was high on the edge before.
- R9: A path request made while `bias_rdy` is low raises `tx_wait` or `rx_wait` and is held. The path enables one cycle after `bias_rdy` rises, and the wait flag then clears.
- R10: `rx_rdy` rises RX_CYC cycles after `rx_en` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 7 | Register write data |
| tx_path_active | input | 1 | Transmit datapath still holds data |
| adc_conv_req | input | 1 | Single-shot conversion request pulse |
| adc_conv_done | input | 1 | Conversion finished pulse |
| dac_pd | output | 4 | Per-DAC power-down |
| dac_rdy | output | 4 | Per-DAC ready |
| adc_pd | output | 1 | Auxiliary ADC power-down |
| adc_rdy | output | 1 | Auxiliary ADC ready |
| aux_clk_stop | output | 1 | Auxiliary section clock stop |
| tx_en | output | 1 | Transmit path enable |
| tx_ctrl_en | output | 1 | Transmit control enable |
| tx_clk_stop | output | 1 | Transmit clock stop |
| tx_wait | output | 1 | Transmit enable pending |
| rx_en | output | 1 | Receive path enable |
| rx_clk_stop | output | 1 | Receive clock stop |
| rx_if_clk_stop | output | 1 | Receive IF clock stop |
| rx_aaf_pd | output | 1 | Receive anti-alias filter power-down |
| rx_rdy | output | 1 | Receive analogue ready |
| rx_wait | output | 1 | Receive enable pending |
| bias_pd | output | 1 | Bias section power-down |
| bias_chain_pd | output | 1 | Bias chain power-down |
| bias_rdy | output | 1 | Bias node recovered |

## Verification
The bench probes the transmit drain interlock. It holds `tx_path_active` high across a disable write, then checks that `tx_en` survives and falls exactly one edge after the status drops. A design that cleared the enable straight from the register would fail this on the first cycle.

Bias gating is checked one cycle on each side of the recovery boundary, with a path request already pending. An off-by-one timer, or a request that is dropped instead of latched, shows up as a path that enables early or never.

Single-shot ADC power is checked before the request, after it and after the done pulse. The clock-stop gate is driven with every blocking condition, so that stopping the clock while a channel or the RAM-DAC is in use is caught.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    localparam int DATA_W = 7;

    localparam logic [1:0] ADDR_PWR = 2'd0;
    localparam logic [1:0] ADDR_TX  = 2'd1;
    localparam logic [1:0] ADDR_RX  = 2'd2;
    localparam logic [1:0] ADDR_AUX = 2'd3;

    // power register bit positions
    localparam int PB_BIAS  = 0;
    localparam int PB_DAC_L = 1;
    localparam int PB_AAF   = 5;
    localparam int PB_CHAIN = 6;

    // auxiliary register bit positions
    localparam int AB_SINGLE = 4;
    localparam int AB_RAMDAC = 5;
    localparam int AB_STOP   = 6;

    localparam logic [DATA_W-1:0] PWR_RST = 7'h7F;
    localparam logic [DATA_W-1:0] AUX_RST = 7'h40;

    typedef struct packed {
        logic [DATA_W-1:0] pwr;
        logic              tx_req;
        logic              rx_req;
        logic [DATA_W-1:0] aux;
        logic              adc_on;
        logic              aux_stop;
    } seq_state_t;
endpackage

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int W = $clog2(CYC + 1);
    localparam logic [W-1:0] LIMIT = W'(CYC);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (cnt_q != LIMIT)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done = (cnt_q == LIMIT);

    // a domain that was off on the last edge cannot report ready
    assert_rdy_drop_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(run) |-> !done);
endmodule

// File: rtl/pwr_path_ctrl.sv
module pwr_path_ctrl #(
    parameter bit HOLD_ON_BUSY = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic gate_ok,
    input  logic busy,
    output logic en,
    output logic pend
);
    logic en_d, en_q;
    logic hold;

    always_comb begin
        hold = HOLD_ON_BUSY ? busy : 1'b0;
        en_d = en_q;
        if (req && gate_ok)
            en_d = 1'b1;
        else if (!req && !hold)
            en_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en_d;
    end

    assign en   = en_q;
    assign pend = req && !en_q;

    // enable only after the bias was ready on the previous edge
    assert_bias_gate_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> $past(gate_ok));

    // an enabled draining path keeps its enable
    assert_drain_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (HOLD_ON_BUSY && en_q && busy) |=> en_q);

    // a held request is applied once the gate opens
    assert_pend_apply_R9: assert property (@(posedge clk) disable iff (rst)
        (req && gate_ok && !en_q) |=> en_q);
endmodule

// File: rtl/xcvr_pwr_seq.sv
module xcvr_pwr_seq
    import pwr_seq_pkg::*;
#(
    parameter int DAC_N    = 4,
    parameter int DAC_CYC  = 500,
    parameter int ADC_CYC  = 3,
    parameter int RX_CYC   = 1000,
    parameter int BIAS_CYC = 200000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_path_active,
    input  logic              adc_conv_req,
    input  logic              adc_conv_done,
    output logic [DAC_N-1:0]  dac_pd,
    output logic [DAC_N-1:0]  dac_rdy,
    output logic              adc_pd,
    output logic              adc_rdy,
    output logic              aux_clk_stop,
    output logic              tx_en,
    output logic              tx_ctrl_en,
    output logic              tx_clk_stop,
    output logic              tx_wait,
    output logic              rx_en,
    output logic              rx_clk_stop,
    output logic              rx_if_clk_stop,
    output logic              rx_aaf_pd,
    output logic              rx_rdy,
    output logic              rx_wait,
    output logic              bias_pd,
    output logic              bias_chain_pd,
    output logic              bias_rdy
);
    localparam int CH_W = AB_SINGLE;

    seq_state_t st_d, st_q;
    logic       chan_none;
    logic       bias_on;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_PWR: st_d.pwr    = wr_data;
                ADDR_TX:  st_d.tx_req = wr_data[0];
                ADDR_RX:  st_d.rx_req = wr_data[0];
                default:  st_d.aux    = wr_data;
            endcase
        end

        chan_none = (st_q.aux[CH_W-1:0] == '0);

        // ADC power: off without a channel, on in continuous mode,
        // otherwise on from request until done
        if (chan_none)
            st_d.adc_on = 1'b0;
        else if (!st_q.aux[AB_SINGLE])
            st_d.adc_on = 1'b1;
        else if (adc_conv_req)
            st_d.adc_on = 1'b1;
        else if (adc_conv_done)
            st_d.adc_on = 1'b0;

        st_d.aux_stop = st_q.aux[AB_STOP] && chan_none && !st_q.aux[AB_RAMDAC];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q          <= '0;
            st_q.pwr      <= PWR_RST;
            st_q.aux      <= AUX_RST;
            st_q.aux_stop <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bias_on       = !st_q.pwr[PB_BIAS] && !st_q.pwr[PB_CHAIN];
    assign bias_pd       = st_q.pwr[PB_BIAS];
    assign bias_chain_pd = st_q.pwr[PB_CHAIN];
    assign rx_aaf_pd     = st_q.pwr[PB_AAF];
    assign dac_pd        = st_q.pwr[PB_DAC_L +: DAC_N];
    assign adc_pd        = !st_q.adc_on;
    assign aux_clk_stop  = st_q.aux_stop;

    for (genvar i = 0; i < DAC_N; i++) begin : g_dac
        pwr_wake_timer #(.CYC(DAC_CYC)) u_dac_tmr (
            .clk(clk), .rst(rst), .run(!dac_pd[i]), .done(dac_rdy[i])
        );
    end

    pwr_wake_timer #(.CYC(ADC_CYC)) u_adc_tmr (
        .clk(clk), .rst(rst), .run(st_q.adc_on), .done(adc_rdy)
    );

    pwr_wake_timer #(.CYC(BIAS_CYC)) u_bias_tmr (
        .clk(clk), .rst(rst), .run(bias_on), .done(bias_rdy)
    );

    pwr_path_ctrl #(.HOLD_ON_BUSY(1'b1)) u_tx_path (
        .clk(clk), .rst(rst), .req(st_q.tx_req), .gate_ok(bias_rdy),
        .busy(tx_path_active), .en(tx_en), .pend(tx_wait)
    );

    pwr_path_ctrl #(.HOLD_ON_BUSY(1'b0)) u_rx_path (
        .clk(clk), .rst(rst), .req(st_q.rx_req), .gate_ok(bias_rdy),
        .busy(1'b0), .en(rx_en), .pend(rx_wait)
    );

    pwr_wake_timer #(.CYC(RX_CYC)) u_rx_tmr (
        .clk(clk), .rst(rst), .run(rx_en), .done(rx_rdy)
    );

    assign tx_ctrl_en     = tx_en;
    assign tx_clk_stop    = !tx_en;
    assign rx_clk_stop    = !rx_en;
    assign rx_if_clk_stop = !rx_en;

    // checker: cycles the ADC has been powered without being ready
    logic [2:0] adc_wait_q;
    always_ff @(posedge clk) begin
        if (rst)
            adc_wait_q <= '0;
        else if (st_q.adc_on && !adc_rdy)
            adc_wait_q <= (adc_wait_q == 3'd7) ? adc_wait_q : adc_wait_q + 3'd1;
        else
            adc_wait_q <= '0;
    end

    assert_adc_wake_R4: assert property (@(posedge clk) disable iff (rst)
        adc_wait_q < 3'd4);

    // the auxiliary clock is never stopped under a powered ADC
    assert_clkstop_R5: assert property (@(posedge clk) disable iff (rst)
        aux_clk_stop |-> adc_pd);

    // the receive clocks run whenever the path is enabled
    assert_rx_clocks_R7: assert property (@(posedge clk) disable iff (rst)
        rx_en |-> (!rx_clk_stop && !rx_if_clk_stop));
endmodule

// File: tb/tb_xcvr_pwr_seq.sv
module tb_xcvr_pwr_seq;
    localparam int DAC_CYC  = 4;
    localparam int ADC_CYC  = 3;
    localparam int RX_CYC   = 6;
    localparam int BIAS_CYC = 20;
    localparam int NVEC     = 8;

    // {addr[1:0], data[6:0], expected dac_pd[3:0], expected aux_clk_stop}
    localparam logic [13:0] VEC [NVEC] = '{
        {2'd0, 7'h7F, 4'hF, 1'b1},
        {2'd0, 7'h7D, 4'hE, 1'b1},
        {2'd0, 7'h6B, 4'h5, 1'b1},
        {2'd3, 7'h41, 4'h5, 1'b0},
        {2'd3, 7'h60, 4'h5, 1'b0},
        {2'd3, 7'h40, 4'h5, 1'b1},
        {2'd3, 7'h00, 4'h5, 1'b0},
        {2'd3, 7'h40, 4'h5, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [6:0] wr_data = '0;
    logic       tx_path_active = 1'b0;
    logic       adc_conv_req = 1'b0;
    logic       adc_conv_done = 1'b0;
    logic [3:0] dac_pd, dac_rdy;
    logic adc_pd, adc_rdy, aux_clk_stop, tx_en, tx_ctrl_en, tx_clk_stop, tx_wait;
    logic rx_en, rx_clk_stop, rx_if_clk_stop, rx_aaf_pd, rx_rdy, rx_wait;
    logic bias_pd, bias_chain_pd, bias_rdy;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    xcvr_pwr_seq #(
        .DAC_N(4), .DAC_CYC(DAC_CYC), .ADC_CYC(ADC_CYC),
        .RX_CYC(RX_CYC), .BIAS_CYC(BIAS_CYC)
    ) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tx_path_active(tx_path_active), .adc_conv_req(adc_conv_req),
        .adc_conv_done(adc_conv_done), .dac_pd(dac_pd), .dac_rdy(dac_rdy),
        .adc_pd(adc_pd), .adc_rdy(adc_rdy), .aux_clk_stop(aux_clk_stop),
        .tx_en(tx_en), .tx_ctrl_en(tx_ctrl_en), .tx_clk_stop(tx_clk_stop),
        .tx_wait(tx_wait), .rx_en(rx_en), .rx_clk_stop(rx_clk_stop),
        .rx_if_clk_stop(rx_if_clk_stop), .rx_aaf_pd(rx_aaf_pd), .rx_rdy(rx_rdy),
        .rx_wait(rx_wait), .bias_pd(bias_pd), .bias_chain_pd(bias_chain_pd),
        .bias_rdy(bias_rdy)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive on a falling edge, return on the falling edge after the write edge
    task automatic reg_write(input logic [1:0] a, input logic [6:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk);
        adc_conv_req = 1'b1;
        @(negedge clk);
        adc_conv_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, checked during reset and after release
        check("R1 dac_pd", 32'(dac_pd), 32'hF);
        check("R1 tx_clk_stop", 32'(tx_clk_stop), 32'd1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 dac_rdy", 32'(dac_rdy), 32'h0);
        check("R1 adc", 32'({adc_pd, adc_rdy, aux_clk_stop}), 32'b101);
        check("R1 tx", 32'({tx_en, tx_ctrl_en, tx_clk_stop}), 32'b001);
        check("R1 rx", 32'({rx_en, rx_clk_stop, rx_if_clk_stop, rx_aaf_pd, rx_rdy}), 32'b01110);
        check("R1 bias", 32'({bias_pd, bias_chain_pd, bias_rdy}), 32'b110);

        // R2 / R5: table of register writes
        for (int i = 0; i < NVEC; i++) begin
            reg_write(VEC[i][13:12], VEC[i][11:5]);
            @(negedge clk);
            check("R2 dac_pd vec", 32'(dac_pd), 32'(VEC[i][4:1]));
            check("R5 aux_clk_stop vec", 32'(aux_clk_stop), 32'(VEC[i][0]));
        end

        // R2: DAC0 wake timing
        reg_write(2'd0, 7'h7F);
        @(negedge clk);
        reg_write(2'd0, 7'h7D);
        repeat (DAC_CYC - 1) @(negedge clk);
        check("R2 dac_rdy early", 32'(dac_rdy), 32'h0);
        @(negedge clk);
        check("R2 dac_rdy on time", 32'(dac_rdy), 32'h1);
        reg_write(2'd0, 7'h7F);
        @(negedge clk);
        check("R2 dac_rdy drop", 32'(dac_rdy), 32'h0);

        // R3: continuous ADC follows channel select
        reg_write(2'd3, 7'h02);
        @(negedge clk);
        check("R3 adc on", 32'(adc_pd), 32'd0);
        check("R5 clk runs with channel", 32'(aux_clk_stop), 32'd0);
        reg_write(2'd3, 7'h00);
        @(negedge clk);
        check("R3 adc off", 32'(adc_pd), 32'd1);

        // R4: single-shot ADC
        reg_write(2'd3, 7'h12);
        repeat (2) @(negedge clk);
        check("R4 idle down", 32'(adc_pd), 32'd1);
        pulse_req();
        check("R4 powered on request", 32'(adc_pd), 32'd0);
        repeat (ADC_CYC - 1) @(negedge clk);
        check("R4 not yet ready", 32'(adc_rdy), 32'd0);
        @(negedge clk);
        check("R4 ready", 32'(adc_rdy), 32'd1);
        @(negedge clk);
        adc_conv_done = 1'b1;
        @(negedge clk);
        adc_conv_done = 1'b0;
        check("R4 down after done", 32'(adc_pd), 32'd1);
        reg_write(2'd3, 7'h40);

        // R9 / R8: transmit request before the bias is up
        reg_write(2'd1, 7'h01);
        @(negedge clk);
        check("R9 tx_wait", 32'(tx_wait), 32'd1);
        check("R8 tx held off", 32'(tx_en), 32'd0);
        reg_write(2'd0, 7'h00);
        repeat (BIAS_CYC - 1) @(negedge clk);
        check("R8 bias_rdy early", 32'(bias_rdy), 32'd0);
        check("R8 tx still off", 32'(tx_en), 32'd0);
        @(negedge clk);
        check("R8 bias_rdy", 32'(bias_rdy), 32'd1);
        check("R9 tx waits one more edge", 32'(tx_en), 32'd0);
        @(negedge clk);
        check("R9 tx applied", 32'({tx_en, tx_ctrl_en, tx_clk_stop, tx_wait}), 32'b1100);

        // R6: disable while draining
        tx_path_active = 1'b1;
        reg_write(2'd1, 7'h00);
        repeat (3) @(negedge clk);
        check("R6 held while active", 32'(tx_en), 32'd1);
        tx_path_active = 1'b0;
        check("R6 held at release", 32'(tx_en), 32'd1);
        @(negedge clk);
        check("R6 dropped", 32'({tx_en, tx_ctrl_en, tx_clk_stop}), 32'b001);

        // R7 / R10: receive path
        check("R7 aaf on", 32'(rx_aaf_pd), 32'd0);
        reg_write(2'd2, 7'h01);
        check("R7 rx not yet", 32'(rx_en), 32'd0);
        @(negedge clk);
        check("R7 rx on", 32'({rx_en, rx_clk_stop, rx_if_clk_stop}), 32'b100);
        repeat (RX_CYC - 1) @(negedge clk);
        check("R10 rx_rdy early", 32'(rx_rdy), 32'd0);
        @(negedge clk);
        check("R10 rx_rdy", 32'(rx_rdy), 32'd1);
        reg_write(2'd0, 7'h20);
        check("R7 aaf off independent", 32'({rx_aaf_pd, rx_en}), 32'b11);
        reg_write(2'd2, 7'h00);
        @(negedge clk);
        check("R7 rx off", 32'({rx_en, rx_clk_stop, rx_if_clk_stop}), 32'b011);

        // R8 / R9: chain power-down forces a new recovery
        reg_write(2'd0, 7'h40);
        check("R8 chain pd", 32'(bias_chain_pd), 32'd1);
        @(negedge clk);
        check("R8 bias_rdy drops", 32'(bias_rdy), 32'd0);
        reg_write(2'd2, 7'h01);
        repeat (3) @(negedge clk);
        check("R9 rx pending", 32'({rx_en, rx_wait}), 32'b01);
        reg_write(2'd0, 7'h00);
        repeat (BIAS_CYC + 1) @(negedge clk);
        check("R9 rx applied", 32'({rx_en, rx_wait}), 32'b10);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule